// File: doc/BRIEF.md
# Hypervisor Configuration Register with Coprocessor Move Access

This block keeps a 32-bit hypervisor configuration word and serves the coprocessor move operations that address it. A move request carries the decoded coprocessor number, the two opcode fields and the two register-number fields, plus a direction bit. The block first checks that the encoding selects this register. It then judges the move against the current exception level, the security state, whether EL2 is enabled and the hypervisor trap bit. The result is one of four outcomes: the move completes, it is ignored because another register was addressed, it is reported as undefined, or it is turned into a trap to EL2 with a syndrome class.

Outcomes are registered. The undefined flag, the trap strobe, its class and its variant bit, and the read data are all valid in the cycle after the request edge, for exactly one cycle. The stored fields drive decode logic elsewhere in the core through a separate output. Two elaboration parameters select reduced builds. In one, the memory-attribute mismatch field is read-as-zero. In the other, EL2 is absent and the whole register reads as zero.

Top module: `hyp_cfg_reg`

## Requirements
- R1: Only coproc=4'b1111, opc1=3'b100, CRn=4'b0001, CRm=4'b0001, opc2=3'b100 selects the register. Any other encoding raises no flag, returns zero read data and leaves the register unchanged.
- R2: A selected move at exception level 0 (`cur_el`=2'd0) raises `undef_o`. It returns zero read data and does not change the register.
- R3: A selected move at level 1 with `el2_enabled`=1 and `hyp_trap_bit`=1 raises `trap_o` with `trap_class`=6'h03. `trap_a32` equals `el2_is_a32`, where 1 means the 32-bit trap variant. Read data is zero and the register is unchanged.
- R4: A selected move at level 1 that does not meet the R3 condition raises `undef_o`.
- R5: At level 2 a write stores the masked write data, and a read returns the stored value.
- R6: At level 3 the move behaves as in R5 when `ns_state`=1 and raises `undef_o` when `ns_state`=0.
- R7: Writable bits are 0, 1, 4, 5, 6, 17, 18, 20 and 22, giving a mask of 32'h0056_0073. All other bits always read zero.
- R8: With `MIOC_RAZ`=1, bit 6 reads zero and writes to it are dropped.
- R9: With `EL2_IMPL`=0, the register always reads zero and writes have no effect.
- R10: Reset (synchronous, active low) clears every stored bit and every response output.
- R11: `undef_o` and `trap_o` are never high together. Each one is high for a single cycle, in the cycle that follows the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Move request present this cycle |
| req_write | input | 1 | 1 = write to register, 0 = read |
| cp_num | input | 4 | Coprocessor number |
| cp_op1 | input | 3 | First opcode field |
| cp_crn | input | 4 | Primary register number |
| cp_crm | input | 4 | Secondary register number |
| cp_op2 | input | 3 | Second opcode field |
| cur_el | input | 2 | Current exception level |
| ns_state | input | 1 | Non-secure state |
| el2_enabled | input | 1 | EL2 enabled in the current state |
| el2_is_a32 | input | 1 | EL2 runs the 32-bit execution state |
| hyp_trap_bit | input | 1 | Trap bit from the hypervisor system trap register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, one cycle after the request |
| undef_o | output | 1 | Access undefined pulse |
| trap_o | output | 1 | Trap-to-EL2 pulse |
| trap_class | output | 6 | Syndrome class of the trap, zero otherwise |
| trap_a32 | output | 1 | Trap uses the 32-bit EL2 variant |
| cfg_o | output | 32 | Stored field values |

## Verification
The bench aims at the points where access permission changes. At EL1 it drives each of the four combinations of enable and trap bit; a design that swapped them would trap on an access that should be undefined. At EL3 it toggles the security state, which catches a design that lets secure-state writes through. It sends writes that must be blocked, and writes whose encoding is off by one field; a block that failed to gate its write enable would change the stored word. All-ones writes, compared against the reduced builds, show any reserved bit, read-as-zero field or absent-EL2 case that is left writable.

// File: rtl/hcfg_pkg.sv
// Package: shared encodings, field positions and outcome type for the
// hypervisor configuration register. Assumes a 32-bit register.
package hcfg_pkg;

    localparam int unsigned REG_W = 32;

    // Selecting encoding
    localparam logic [3:0] SEL_CP  = 4'b1111;
    localparam logic [2:0] SEL_OP1 = 3'b100;
    localparam logic [3:0] SEL_CRN = 4'b0001;
    localparam logic [3:0] SEL_CRM = 4'b0001;
    localparam logic [2:0] SEL_OP2 = 3'b100;

    // Field positions (decoded by neighbouring logic)
    localparam int unsigned F_S2_DNC   = 0;
    localparam int unsigned F_S2_INC   = 1;
    localparam int unsigned F_ERR_TRAP = 4;
    localparam int unsigned F_ABT_RT   = 5;
    localparam int unsigned F_MISMATCH = 6;
    localparam int unsigned F_ID4_TRAP = 17;
    localparam int unsigned F_ICIS_TR  = 18;
    localparam int unsigned F_POU_TRAP = 20;
    localparam int unsigned F_TLBIS_TR = 22;

    localparam logic [5:0] TRAP_EC = 6'h03;

    typedef enum logic [1:0] {
        OUT_NONE  = 2'd0,
        OUT_OK    = 2'd1,
        OUT_UNDEF = 2'd2,
        OUT_TRAP  = 2'd3
    } outcome_e;

    // Writable bit mask for a given build variant.
    function automatic logic [REG_W-1:0] wr_mask(input bit mioc_raz, input bit el2_impl);
        logic [REG_W-1:0] m;
        m = '0;
        m[F_S2_DNC]   = 1'b1;
        m[F_S2_INC]   = 1'b1;
        m[F_ERR_TRAP] = 1'b1;
        m[F_ABT_RT]   = 1'b1;
        m[F_MISMATCH] = !mioc_raz;
        m[F_ID4_TRAP] = 1'b1;
        m[F_ICIS_TR]  = 1'b1;
        m[F_POU_TRAP] = 1'b1;
        m[F_TLBIS_TR] = 1'b1;
        if (!el2_impl) m = '0;
        return m;
    endfunction

endpackage

// File: rtl/hcfg_decode.sv
// Module: hcfg_decode
// Combinational access check. It matches the coprocessor encoding, then
// grades the move by exception level, security state and trap controls.
// Assumes cur_el holds a legal level in 0..3.
module hcfg_decode
    import hcfg_pkg::*;
(
    input  logic       req_valid,
    input  logic [3:0] cp_num,
    input  logic [2:0] cp_op1,
    input  logic [3:0] cp_crn,
    input  logic [3:0] cp_crm,
    input  logic [2:0] cp_op2,
    input  logic [1:0] cur_el,
    input  logic       ns_state,
    input  logic       el2_enabled,
    input  logic       hyp_trap_bit,
    output logic       sel,
    output outcome_e   outcome
);

    // Encoding match for this register
    always_comb begin
        sel = req_valid && (cp_num == SEL_CP) && (cp_op1 == SEL_OP1) &&
              (cp_crn == SEL_CRN) && (cp_crm == SEL_CRM) && (cp_op2 == SEL_OP2);
    end

    // Permission grading per exception level
    always_comb begin
        outcome = OUT_NONE;
        if (sel) begin
            unique case (cur_el)
                2'd0: outcome = OUT_UNDEF;
                2'd1: outcome = (el2_enabled && hyp_trap_bit) ? OUT_TRAP : OUT_UNDEF;
                2'd2: outcome = OUT_OK;
                default: outcome = ns_state ? OUT_OK : OUT_UNDEF;
            endcase
        end
    end

endmodule

// File: rtl/hcfg_store.sv
// Module: hcfg_store
// Holds the configuration word. Only bits in the variant mask can be set;
// everything else stays zero. Assumes wr_en is already permission-checked.
module hcfg_store
    import hcfg_pkg::*;
#(
    parameter bit MIOC_RAZ = 1'b0,
    parameter bit EL2_IMPL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] cfg_q
);

    localparam logic [REG_W-1:0] MASK = wr_mask(MIOC_RAZ, EL2_IMPL);

    // Register update with reserved bits forced to zero
    always_ff @(posedge clk) begin
        if (!rst_n)     cfg_q <= '0;
        else if (wr_en) cfg_q <= wdata & MASK;
    end

    // R2/R3/R4: without a granted write the stored word holds
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cfg_q));

endmodule

// File: rtl/hyp_cfg_reg.sv
// Module: hyp_cfg_reg (top)
// Coprocessor-move front end for the hypervisor configuration register.
// It registers the outcome of each request: read data, an undefined pulse
// or a trap pulse with class and variant. Assumes one request per cycle at
// most, and that exception entry is handled elsewhere.
module hyp_cfg_reg
    import hcfg_pkg::*;
#(
    parameter bit MIOC_RAZ = 1'b0,
    parameter bit EL2_IMPL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [3:0]       cp_num,
    input  logic [2:0]       cp_op1,
    input  logic [3:0]       cp_crn,
    input  logic [3:0]       cp_crm,
    input  logic [2:0]       cp_op2,
    input  logic [1:0]       cur_el,
    input  logic             ns_state,
    input  logic             el2_enabled,
    input  logic             el2_is_a32,
    input  logic             hyp_trap_bit,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    output logic             undef_o,
    output logic             trap_o,
    output logic [5:0]       trap_class,
    output logic             trap_a32,
    output logic [REG_W-1:0] cfg_o
);

    logic     sel;
    outcome_e outcome;
    logic     wr_en;

    hcfg_decode u_dec (
        .req_valid    (req_valid),
        .cp_num       (cp_num),
        .cp_op1       (cp_op1),
        .cp_crn       (cp_crn),
        .cp_crm       (cp_crm),
        .cp_op2       (cp_op2),
        .cur_el       (cur_el),
        .ns_state     (ns_state),
        .el2_enabled  (el2_enabled),
        .hyp_trap_bit (hyp_trap_bit),
        .sel          (sel),
        .outcome      (outcome)
    );

    // Write enable only for a granted write
    always_comb wr_en = (outcome == OUT_OK) && req_write;

    hcfg_store #(.MIOC_RAZ(MIOC_RAZ), .EL2_IMPL(EL2_IMPL)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .wdata (wdata),
        .cfg_q (cfg_o)
    );

    // Registered response for the request of the previous cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata      <= '0;
            undef_o    <= 1'b0;
            trap_o     <= 1'b0;
            trap_class <= '0;
            trap_a32   <= 1'b0;
        end else begin
            rdata      <= (outcome == OUT_OK && !req_write) ? cfg_o : '0;
            undef_o    <= (outcome == OUT_UNDEF);
            trap_o     <= (outcome == OUT_TRAP);
            trap_class <= (outcome == OUT_TRAP) ? TRAP_EC : 6'h00;
            trap_a32   <= (outcome == OUT_TRAP) && el2_is_a32;
        end
    end

    p_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(undef_o && trap_o));
    p_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (undef_o || trap_o) |-> $past(req_valid));
    p_el0_undef_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && cur_el == 2'd0) |=> undef_o);
    p_secure_el3_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && cur_el == 2'd3 && !ns_state) |=> (undef_o && rdata == '0));
    p_trap_class_r3: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |-> (trap_class == 6'h03 && rdata == '0));
    p_nosel_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> (!undef_o && !trap_o && rdata == '0));

endmodule

// File: tb/tb_hyp_cfg_reg.sv
// Scoreboard bench: the driver pushes expected responses, and the monitor
// pops and compares them one cycle after each request edge.
module tb_hyp_cfg_reg;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [3:0]  cp_num = '0, cp_crn = '0, cp_crm = '0;
    logic [2:0]  cp_op1 = '0, cp_op2 = '0;
    logic [1:0]  cur_el = '0;
    logic        ns_state = 1'b0, el2_enabled = 1'b0, el2_is_a32 = 1'b0, hyp_trap_bit = 1'b0;
    logic [31:0] wdata = '0;

    logic [31:0] rdata, cfg_o, rdata_raz, cfg_raz, rdata_no, cfg_no;
    logic        undef_o, trap_o, trap_a32;
    logic        undef_raz, trap_raz, a32_raz, undef_no, trap_no, a32_no;
    logic [5:0]  trap_class, cls_raz, cls_no;

    int n_chk = 0, n_fail = 0;

    always #2 clk = ~clk;  // 250 MHz

    hyp_cfg_reg dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .cp_num(cp_num), .cp_op1(cp_op1), .cp_crn(cp_crn), .cp_crm(cp_crm), .cp_op2(cp_op2),
        .cur_el(cur_el), .ns_state(ns_state), .el2_enabled(el2_enabled),
        .el2_is_a32(el2_is_a32), .hyp_trap_bit(hyp_trap_bit), .wdata(wdata),
        .rdata(rdata), .undef_o(undef_o), .trap_o(trap_o), .trap_class(trap_class),
        .trap_a32(trap_a32), .cfg_o(cfg_o));

    hyp_cfg_reg #(.MIOC_RAZ(1'b1)) dut_raz (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .cp_num(cp_num), .cp_op1(cp_op1), .cp_crn(cp_crn), .cp_crm(cp_crm), .cp_op2(cp_op2),
        .cur_el(cur_el), .ns_state(ns_state), .el2_enabled(el2_enabled),
        .el2_is_a32(el2_is_a32), .hyp_trap_bit(hyp_trap_bit), .wdata(wdata),
        .rdata(rdata_raz), .undef_o(undef_raz), .trap_o(trap_raz), .trap_class(cls_raz),
        .trap_a32(a32_raz), .cfg_o(cfg_raz));

    hyp_cfg_reg #(.EL2_IMPL(1'b0)) dut_noel2 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .cp_num(cp_num), .cp_op1(cp_op1), .cp_crn(cp_crn), .cp_crm(cp_crm), .cp_op2(cp_op2),
        .cur_el(cur_el), .ns_state(ns_state), .el2_enabled(el2_enabled),
        .el2_is_a32(el2_is_a32), .hyp_trap_bit(hyp_trap_bit), .wdata(wdata),
        .rdata(rdata_no), .undef_o(undef_no), .trap_o(trap_no), .trap_class(cls_no),
        .trap_a32(a32_no), .cfg_o(cfg_no));

    typedef struct {
        logic        u, t, a32;
        logic [31:0] rd, rd_raz, cfg, cfg_r;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    logic [31:0] model = '0, model_raz = '0;
    logic        cap = 1'b0;

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Driver: one request, expected response pushed to the scoreboard
    task automatic acc(input string tag, input logic wr, input logic [1:0] el, input logic ns,
                       input logic en, input logic a32, input logic t1,
                       input logic [31:0] wd, input int bad);
        exp_t e;
        logic sel, ok;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; cur_el = el; ns_state = ns;
        el2_enabled = en; el2_is_a32 = a32; hyp_trap_bit = t1; wdata = wd;
        cp_num = (bad == 1) ? 4'b1110 : 4'b1111;
        cp_op1 = (bad == 2) ? 3'b000  : 3'b100;
        cp_crn = (bad == 3) ? 4'b0000 : 4'b0001;
        cp_crm = (bad == 4) ? 4'b0010 : 4'b0001;
        cp_op2 = (bad == 5) ? 3'b000  : 3'b100;
        sel = (bad == 0);
        e.u = 0; e.t = 0; e.a32 = 0; ok = 0;
        if (sel) begin
            case (el)
                2'd0: e.u = 1;
                2'd1: begin e.t = en && t1; e.u = !(en && t1); e.a32 = en && t1 && a32; end
                2'd2: ok = 1;
                default: begin ok = ns; e.u = !ns; end
            endcase
        end
        e.rd = (ok && !wr) ? model : 32'h0;
        e.rd_raz = (ok && !wr) ? model_raz : 32'h0;
        if (ok && wr) begin
            model = wd & 32'h0056_0073;
            model_raz = wd & 32'h0056_0033;
        end
        e.cfg = model; e.cfg_r = model_raz; e.tag = tag;
        sb.push_back(e);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    always @(posedge clk) cap <= req_valid;

    // Monitor: compare one cycle after each request edge
    always @(negedge clk) begin
        if (cap && sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            chk(e.tag, "undef", {31'b0, undef_o}, {31'b0, e.u});
            chk(e.tag, "trap", {31'b0, trap_o}, {31'b0, e.t});
            chk(e.tag, "class", {26'b0, trap_class}, e.t ? 32'h3 : 32'h0);
            chk(e.tag, "a32", {31'b0, trap_a32}, {31'b0, e.a32});
            chk(e.tag, "rdata", rdata, e.rd);
            chk(e.tag, "cfg", cfg_o, e.cfg);
            chk(e.tag, "rdata_raz", rdata_raz, e.rd_raz);
            chk(e.tag, "cfg_raz", cfg_raz, e.cfg_r);
            chk(e.tag, "rdata_noel2", rdata_no, 32'h0);
            chk(e.tag, "cfg_noel2", cfg_no, 32'h0);
            chk(e.tag, "excl_R11", {31'b0, undef_o && trap_o}, 32'h0);
        end
    end

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1'b1;
                // R10 reset state
                chk("R10", "cfg", cfg_o, 32'h0);
                chk("R10", "rdata", rdata, 32'h0);
                chk("R10", "flags", {30'b0, undef_o, trap_o}, 32'h0);
                // R5 write and read at EL2, R7 reserved bits, R8/R9 variants
                acc("R5_wr", 1, 2'd2, 1, 1, 0, 0, 32'hFFFF_FFFF, 0);
                acc("R7_rd", 0, 2'd2, 1, 1, 0, 0, 32'h0, 0);
                acc("R8_R9_rd", 0, 2'd2, 1, 1, 0, 0, 32'h0, 0);
                // R2 EL0 write and read
                acc("R2_wr", 1, 2'd0, 1, 1, 0, 1, 32'h0, 0);
                acc("R2_rd", 0, 2'd0, 1, 1, 0, 1, 32'h0, 0);
                // R3 traps, both variants, write blocked
                acc("R3_a64", 1, 2'd1, 1, 1, 0, 1, 32'h0, 0);
                acc("R3_a32", 0, 2'd1, 1, 1, 1, 1, 32'h0, 0);
                // R4 EL1 without trap condition
                acc("R4_noen", 1, 2'd1, 1, 0, 1, 1, 32'h0, 0);
                acc("R4_not1", 1, 2'd1, 1, 1, 1, 0, 32'h0, 0);
                acc("R4_none", 0, 2'd1, 1, 0, 0, 0, 32'h0, 0);
                // R6 EL3
                acc("R6_sec_wr", 1, 2'd3, 0, 1, 0, 0, 32'h0, 0);
                acc("R6_ns_wr", 1, 2'd3, 1, 1, 0, 0, 32'h0040_0051, 0);
                acc("R6_ns_rd", 0, 2'd3, 1, 1, 0, 0, 32'h0, 0);
                acc("R6_sec_rd", 0, 2'd3, 0, 1, 0, 0, 32'h0, 0);
                // R1 each field mismatched, writes ignored
                for (int b = 1; b <= 5; b++) acc("R1_bad", 1, 2'd2, 1, 1, 0, 0, 32'hFFFF_FFFF, b);
                acc("R1_rdback", 0, 2'd2, 1, 1, 0, 0, 32'h0, 0);
                // R7/R8 bit 6 only and reserved-only patterns
                acc("R8_b6", 1, 2'd2, 1, 1, 0, 0, 32'h0000_0040, 0);
                acc("R8_b6rd", 0, 2'd2, 1, 1, 0, 0, 32'h0, 0);
                acc("R7_resv", 1, 2'd2, 1, 1, 0, 0, 32'hFFA9_FF8C, 0);
                acc("R7_resvrd", 0, 2'd2, 1, 1, 0, 0, 32'h0, 0);
                // R11 back-to-back undefined then trap
                acc("R11_u", 0, 2'd0, 1, 1, 0, 1, 32'h0, 0);
                acc("R11_t", 0, 2'd1, 1, 1, 0, 1, 32'h0, 0);
                @(negedge clk);
                @(negedge clk);
                chk("R11", "idle_flags", {30'b0, undef_o, trap_o}, 32'h0);
            end
            begin
                repeat (20000) @(posedge clk);
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule